// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits in the always-on part of a small microcontroller-style system. It decides which reduced-power mode the system enters when the CPU issues a wait-for-interrupt or wait-for-event, and it drives the clock gates, oscillator and PLL enables, regulator mode pins and core-domain power switch. There are three modes. Sleep stops only the CPU clock. Deep-sleep stops every core-domain clock, turns off all three clock sources and can put the regulator into a low-power or low-drive state. Standby removes core-domain power completely.

Software programs a small control register and reads a sticky status register through a plain register port. The status register is in the always-on domain and keeps its contents through the power-on reset that ends Standby. The CPU pulses `slp_req` for one cycle when it executes its wait instruction, and holds `slp_deep` high during that pulse if it wants a deep mode. Sleep and Deep-sleep end when `irq_pend` is high. Standby ends when the reset pin goes low, the RTC alarm or watchdog reset fires, or the wakeup pin rises. All inputs are taken to be synchronous to `clk`. The controller has no streaming data path, so none of its pins use a valid/ready handshake.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After `rst_n` is released the mode is Run (`mode_o`=0). `cpu_clk_en`, `core_clk_en`, `irc_en`, `xtal_en`, `pll_en`, `ldo_on` and `core_pwr_on` are high. `ldo_lowpwr`, `ldo_lowdrv` and `por_out` are low. Both registers read as zero.
- R2: A `slp_req` pulse in Run with `slp_deep` low enters Sleep (`mode_o`=1) on the next edge. In Sleep only `cpu_clk_en` is low, and every other output keeps its Run value.
- R3: When `irq_pend` is high in Sleep, the block returns to Run on the next edge.
- R4: A `slp_req` pulse in Run with `slp_deep` high, control bit 1 clear and `exti_pend` all zero enters Deep-sleep (`mode_o`=2). In Deep-sleep `cpu_clk_en`, `core_clk_en`, `irc_en`, `xtal_en` and `pll_en` are low, while `ldo_on` and `core_pwr_on` stay high.
- R5: In Deep-sleep `ldo_lowpwr` equals control bit 0. In every other mode it is low.
- R6: `ldo_lowdrv` is high only in Deep-sleep and only when control bits [3:2] equal 2'b11. When they do, it follows control bit 4 if control bit 0 is clear, and control bit 5 if control bit 0 is set. The values 2'b00, 2'b01 and 2'b10 all give normal drive.
- R7: A Deep-sleep request made while any bit of `exti_pend` is set is dropped. The block stays in Run and every output keeps its value.
- R8: When `irq_pend` is high in Deep-sleep, the block enters a settle state (`mode_o`=3). In that state the three oscillator enables are high, `ldo_lowpwr` and `ldo_lowdrv` are low, and both clock enables are low. After exactly `WAKE_CYC` cycles in the settle state the block is back in Run.
- R9: A `slp_req` pulse in Run with `slp_deep` high and control bit 1 set enters Standby (`mode_o`=4), even if `exti_pend` has bits set. In Standby every output is low.
- R10: Status bit 1 becomes 1 on the edge that enters Standby and keeps that value through the Standby exit. Writing a 1 to bit 1 of the status address clears it. Writing a 0 there has no effect.
- R11: Standby ends on any of four events: `rst_pin_n` low, `rtc_alarm` high, `wdt_rst` high, or a 0-to-1 change of `wkup_pin` seen between two edges. A wakeup pin that is already high and stays high does not end Standby. On exit the block spends `POR_CYC` cycles in a reset state (`mode_o`=5). In that state `por_out`, `core_pwr_on`, `ldo_on` and the oscillator enables are high, the clock enables are low, and the control register is cleared. After that the block returns to Run.
- R12: Status bit 0 becomes 1 when Standby is ended by the RTC alarm or by the wakeup pin edge, and stays 0 for the other two sources. Writing a 1 to bit 0 of the status address clears it.
- R13: `slp_req` pulses are ignored in every mode other than Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low power-on reset of the always-on logic |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data of the selected register |
| slp_req | input | 1 | One-cycle wait-for-interrupt/event pulse from the CPU |
| slp_deep | input | 1 | Deep-mode qualifier that goes with `slp_req` |
| irq_pend | input | 1 | An unmasked interrupt or event is pending |
| exti_pend | input | EXTI_W | Pending flags of the external-interrupt lines |
| rst_pin_n | input | 1 | External reset pin, active low |
| rtc_alarm | input | 1 | RTC alarm |
| wdt_rst | input | 1 | Watchdog reset request |
| wkup_pin | input | 1 | Dedicated wakeup pin |
| mode_o | output | 3 | Current controller state |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| core_clk_en | output | 1 | Enable for the other core-domain clocks |
| irc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| ldo_on | output | 1 | Regulator enable |
| ldo_lowpwr | output | 1 | Regulator low-power mode |
| ldo_lowdrv | output | 1 | Regulator low-drive mode |
| core_pwr_on | output | 1 | Core-domain power switch |
| por_out | output | 1 | Power-on reset to the core domain |

## Verification
The hardest case to reach is a Standby exit that is not a real exit: the wakeup pin is already high when Standby is entered and stays high. The stimulus raises the pin while the block is still in Run, enters Standby, waits several cycles to show the mode has not changed, then drops the pin and raises it again to cause a proper exit. Each of the four exit sources gets its own Standby round trip. On each trip the bench reads back the cleared control register and the kept status flags, so the split between state that is lost and state that survives is checked at the register port.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_DEEP  = 3'd2,
    ST_WAKE  = 3'd3,
    ST_STBY  = 3'd4,
    ST_POR   = 3'd5
  } lpm_state_e;

  // control register layout, bit 5 down to bit 0
  typedef struct packed {
    logic       drv_lp_sel;   // low-drive select when regulator is low-power
    logic       drv_np_sel;   // low-drive select when regulator is normal-power
    logic [1:0] drv_en;       // low-drive enable, active only at 2'b11
    logic       stby_sel;     // deep request goes to standby
    logic       reg_lp;       // regulator low-power in deep-sleep
  } lpm_ctrl_t;

  localparam int REG_W    = 6;
  localparam int STAT_WUF = 0;
  localparam int STAT_STB = 1;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             core_clr,
  input  logic             stbf_set,
  input  logic             wuf_set,
  output lpm_ctrl_t        ctrl,
  output logic             stbf,
  output logic             wuf,
  output logic [REG_W-1:0] rdata
);

  // control register: core domain, lost on the standby power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ctrl <= '0;
    else if (core_clr)      ctrl <= '0;
    else if (wr && !sel)    ctrl <= lpm_ctrl_t'(wdata);
  end

  // status flags: always-on, set has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stbf <= 1'b0;
      wuf  <= 1'b0;
    end else begin
      if (stbf_set)                          stbf <= 1'b1;
      else if (wr && sel && wdata[STAT_STB]) stbf <= 1'b0;
      if (wuf_set)                           wuf  <= 1'b1;
      else if (wr && sel && wdata[STAT_WUF]) wuf  <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[STAT_STB] = stbf;
      rdata[STAT_WUF] = wuf;
    end else begin
      rdata = REG_W'(ctrl);
    end
  end

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stby,
  input  logic rst_pin_n,
  input  logic rtc_alarm,
  input  logic wdt_rst,
  input  logic wkup_pin,
  output logic exit_req,
  output logic wuf_hit
);

  logic wk_q;
  logic wk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wk_q <= 1'b0;
    else        wk_q <= wkup_pin;
  end

  assign wk_rise  = wkup_pin && !wk_q;
  assign exit_req = in_stby && (!rst_pin_n || rtc_alarm || wdt_rst || wk_rise);
  assign wuf_hit  = in_stby && (rtc_alarm || wk_rise);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int EXTI_W   = 16,
  parameter int WAKE_CYC = 8,
  parameter int POR_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slp_req,
  input  logic              slp_deep,
  input  logic              irq_pend,
  input  logic [EXTI_W-1:0] exti_pend,
  input  logic              stby_sel,
  input  logic              stby_exit,
  output lpm_state_e        state,
  output logic              stby_enter,
  output logic              por_enter
);

  localparam int MAXC  = (WAKE_CYC > POR_CYC) ? WAKE_CYC : POR_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  lpm_state_e       nxt;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             exti_any;

  assign exti_any = |exti_pend;

  always_comb begin
    nxt   = state;
    cnt_d = cnt;
    unique case (state)
      ST_RUN: begin
        if (slp_req) begin
          if (!slp_deep)     nxt = ST_SLEEP;
          else if (stby_sel) nxt = ST_STBY;
          else if (!exti_any) nxt = ST_DEEP;
        end
      end
      ST_SLEEP: if (irq_pend) nxt = ST_RUN;
      ST_DEEP: begin
        if (irq_pend) begin
          nxt   = ST_WAKE;
          cnt_d = CNT_W'(WAKE_CYC - 1);
        end
      end
      ST_WAKE: begin
        if (cnt == '0) nxt = ST_RUN;
        else           cnt_d = cnt - 1'b1;
      end
      ST_STBY: begin
        if (stby_exit) begin
          nxt   = ST_POR;
          cnt_d = CNT_W'(POR_CYC - 1);
        end
      end
      ST_POR: begin
        if (cnt == '0) nxt = ST_RUN;
        else           cnt_d = cnt - 1'b1;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_d;
    end
  end

  assign stby_enter = (state == ST_RUN)  && (nxt == ST_STBY);
  assign por_enter  = (state == ST_STBY) && (nxt == ST_POR);

endmodule

// File: rtl/lpm_pwr_decode.sv
module lpm_pwr_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       reg_lp,
  input  logic [1:0] drv_en,
  input  logic       drv_np_sel,
  input  logic       drv_lp_sel,
  output logic       cpu_clk_en,
  output logic       core_clk_en,
  output logic       osc_on,
  output logic       ldo_on,
  output logic       ldo_lowpwr,
  output logic       ldo_lowdrv,
  output logic       core_pwr_on,
  output logic       por_out
);

  logic in_deep;
  assign in_deep = (state == ST_DEEP);

  always_comb begin
    cpu_clk_en  = (state == ST_RUN);
    core_clk_en = (state == ST_RUN) || (state == ST_SLEEP);
    osc_on      = (state != ST_DEEP) && (state != ST_STBY);
    ldo_on      = (state != ST_STBY);
    core_pwr_on = (state != ST_STBY);
    por_out     = (state == ST_POR);
    ldo_lowpwr  = in_deep && reg_lp;
    ldo_lowdrv  = in_deep && (drv_en == 2'b11) && (reg_lp ? drv_lp_sel : drv_np_sel);
  end

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int EXTI_W   = 16,
  parameter int WAKE_CYC = 8,
  parameter int POR_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [5:0]        reg_wdata,
  output logic [5:0]        reg_rdata,
  input  logic              slp_req,
  input  logic              slp_deep,
  input  logic              irq_pend,
  input  logic [EXTI_W-1:0] exti_pend,
  input  logic              rst_pin_n,
  input  logic              rtc_alarm,
  input  logic              wdt_rst,
  input  logic              wkup_pin,
  output logic [2:0]        mode_o,
  output logic              cpu_clk_en,
  output logic              core_clk_en,
  output logic              irc_en,
  output logic              xtal_en,
  output logic              pll_en,
  output logic              ldo_on,
  output logic              ldo_lowpwr,
  output logic              ldo_lowdrv,
  output logic              core_pwr_on,
  output logic              por_out
);

  localparam int NOSC = 3;

  lpm_state_e      state;
  lpm_ctrl_t       ctrl_q;
  logic            stbf_q, wuf_q;
  logic            stby_enter, por_enter;
  logic            stby_exit, wuf_hit;
  logic            osc_on;
  logic [NOSC-1:0] osc_vec;

  lpm_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .core_clr (por_enter),
    .stbf_set (stby_enter),
    .wuf_set  (wuf_hit),
    .ctrl     (ctrl_q),
    .stbf     (stbf_q),
    .wuf      (wuf_q),
    .rdata    (reg_rdata)
  );

  lpm_wake u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stby   (state == ST_STBY),
    .rst_pin_n (rst_pin_n),
    .rtc_alarm (rtc_alarm),
    .wdt_rst   (wdt_rst),
    .wkup_pin  (wkup_pin),
    .exit_req  (stby_exit),
    .wuf_hit   (wuf_hit)
  );

  lpm_fsm #(
    .EXTI_W   (EXTI_W),
    .WAKE_CYC (WAKE_CYC),
    .POR_CYC  (POR_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .slp_req    (slp_req),
    .slp_deep   (slp_deep),
    .irq_pend   (irq_pend),
    .exti_pend  (exti_pend),
    .stby_sel   (ctrl_q.stby_sel),
    .stby_exit  (stby_exit),
    .state      (state),
    .stby_enter (stby_enter),
    .por_enter  (por_enter)
  );

  lpm_pwr_decode u_dec (
    .state       (state),
    .reg_lp      (ctrl_q.reg_lp),
    .drv_en      (ctrl_q.drv_en),
    .drv_np_sel  (ctrl_q.drv_np_sel),
    .drv_lp_sel  (ctrl_q.drv_lp_sel),
    .cpu_clk_en  (cpu_clk_en),
    .core_clk_en (core_clk_en),
    .osc_on      (osc_on),
    .ldo_on      (ldo_on),
    .ldo_lowpwr  (ldo_lowpwr),
    .ldo_lowdrv  (ldo_lowdrv),
    .core_pwr_on (core_pwr_on),
    .por_out     (por_out)
  );

  // one enable per clock source: internal RC, crystal, PLL
  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    assign osc_vec[g] = osc_on;
  end

  assign irc_en  = osc_vec[0];
  assign xtal_en = osc_vec[1];
  assign pll_en  = osc_vec[2];
  assign mode_o  = state;

endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       slp_req,
  input logic       slp_deep,
  input logic       irq_pend,
  input logic       exti_any,
  input logic       stby_sel,
  input logic [1:0] drv_en,
  input logic       stbf,
  input logic       cpu_clk_en,
  input logic       core_clk_en,
  input logic       irc_en,
  input logic       xtal_en,
  input logic       pll_en,
  input logic       ldo_on,
  input logic       ldo_lowpwr,
  input logic       ldo_lowdrv,
  input logic       core_pwr_on,
  input logic       por_out
);

  AST_SLEEP_ONLY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (!cpu_clk_en && core_clk_en && irc_en && xtal_en && pll_en && ldo_on)); // R2

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && irq_pend) |=> (mode == 3'd0)); // R3

  AST_DEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (!core_clk_en && !irc_en && !xtal_en && !pll_en && ldo_on && core_pwr_on)); // R4

  AST_LOWDRV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_lowdrv |-> (mode == 3'd2 && drv_en == 2'b11)); // R6

  AST_LOWPWR_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_lowpwr |-> (mode == 3'd2)); // R5

  AST_DEEP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && slp_req && slp_deep && !stby_sel && exti_any) |=> (mode == 3'd0)); // R7

  AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (!core_pwr_on && !ldo_on && !irc_en && !xtal_en && !pll_en && !cpu_clk_en)); // R9

  AST_STBY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> stbf); // R10

  AST_STBY_LEAVE_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> (mode == 3'd4 || mode == 3'd5)); // R11

  AST_POR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    por_out |-> (mode == 3'd5 && core_pwr_on && !cpu_clk_en)); // R11

  AST_SLEEP_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !irq_pend) |=> (mode == 3'd1)); // R13

endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode_o),
  .slp_req     (slp_req),
  .slp_deep    (slp_deep),
  .irq_pend    (irq_pend),
  .exti_any    (|exti_pend),
  .stby_sel    (ctrl_q.stby_sel),
  .drv_en      (ctrl_q.drv_en),
  .stbf        (stbf_q),
  .cpu_clk_en  (cpu_clk_en),
  .core_clk_en (core_clk_en),
  .irc_en      (irc_en),
  .xtal_en     (xtal_en),
  .pll_en      (pll_en),
  .ldo_on      (ldo_on),
  .ldo_lowpwr  (ldo_lowpwr),
  .ldo_lowdrv  (ldo_lowdrv),
  .core_pwr_on (core_pwr_on),
  .por_out     (por_out)
);

// File: tb/lpm_entry_ctrl_tb_top.sv
module lpm_entry_ctrl_tb_top;

  localparam int CLK_P  = 10;
  localparam int EXTI_W = 16;
  localparam int WAKE_C = 5;
  localparam int POR_C  = 3;

  // packed outputs: cpu, core, irc, xtal, pll, ldo_on, lowpwr, lowdrv, pwr, por
  localparam logic [9:0] O_RUN   = 10'b11111_1_0_0_1_0;
  localparam logic [9:0] O_SLEEP = 10'b01111_1_0_0_1_0;
  localparam logic [9:0] O_WAKE  = 10'b00111_1_0_0_1_0;
  localparam logic [9:0] O_STBY  = 10'b00000_0_0_0_0_0;
  localparam logic [9:0] O_POR   = 10'b00111_1_0_0_1_1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic slp_req = 1'b0, slp_deep = 1'b0, irq_pend = 1'b0;
  logic [EXTI_W-1:0] exti_pend = '0;
  logic rst_pin_n = 1'b1, rtc_alarm = 1'b0, wdt_rst = 1'b0, wkup_pin = 1'b0;
  logic [2:0] mode_o;
  logic cpu_clk_en, core_clk_en, irc_en, xtal_en, pll_en;
  logic ldo_on, ldo_lowpwr, ldo_lowdrv, core_pwr_on, por_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lpm_entry_ctrl #(.EXTI_W(EXTI_W), .WAKE_CYC(WAKE_C), .POR_CYC(POR_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slp_req(slp_req),
    .slp_deep(slp_deep), .irq_pend(irq_pend), .exti_pend(exti_pend),
    .rst_pin_n(rst_pin_n), .rtc_alarm(rtc_alarm), .wdt_rst(wdt_rst),
    .wkup_pin(wkup_pin), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
    .core_clk_en(core_clk_en), .irc_en(irc_en), .xtal_en(xtal_en),
    .pll_en(pll_en), .ldo_on(ldo_on), .ldo_lowpwr(ldo_lowpwr),
    .ldo_lowdrv(ldo_lowdrv), .core_pwr_on(core_pwr_on), .por_out(por_out)
  );

  function automatic logic [9:0] outs();
    return {cpu_clk_en, core_clk_en, irc_en, xtal_en, pll_en,
            ldo_on, ldo_lowpwr, ldo_lowdrv, core_pwr_on, por_out};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic sel, logic [5:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(logic sel, output logic [5:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic req_sleep(logic deep);
    slp_req = 1'b1; slp_deep = deep;
    step(1);
    slp_req = 1'b0; slp_deep = 1'b0;
  endtask

  task automatic t_reset();
    logic [5:0] d;
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 outputs", 32'(outs()), 32'(O_RUN));
    rd_reg(1'b0, d); chk("R1 ctrl", 32'(d), 0);
    rd_reg(1'b1, d); chk("R1 status", 32'(d), 0);
  endtask

  task automatic t_sleep();
    req_sleep(1'b0);
    chk("R2 mode", 32'(mode_o), 1);
    chk("R2 outputs", 32'(outs()), 32'(O_SLEEP));
    req_sleep(1'b1);
    chk("R13 req in sleep", 32'(mode_o), 1);
    step(2);
    chk("R3 stays without irq", 32'(mode_o), 1);
    irq_pend = 1'b1;
    step(1);
    irq_pend = 1'b0;
    chk("R3 mode", 32'(mode_o), 0);
    chk("R3 outputs", 32'(outs()), 32'(O_RUN));
  endtask

  task automatic t_deep(logic lp, logic [1:0] den, logic np_s, logic lp_s);
    logic ld;
    wr_reg(1'b0, {lp_s, np_s, den, 1'b0, lp});
    req_sleep(1'b1);
    ld = (den == 2'b11) && (lp ? lp_s : np_s);
    chk("R4 mode", 32'(mode_o), 2);
    chk("R4 R5 R6 outputs", 32'(outs()), 32'({5'b00000, 1'b1, lp, ld, 1'b1, 1'b0}));
    req_sleep(1'b0);
    chk("R13 req in deep", 32'(mode_o), 2);
    irq_pend = 1'b1;
    step(1);
    irq_pend = 1'b0;
    chk("R8 settle mode", 32'(mode_o), 3);
    chk("R8 settle outputs", 32'(outs()), 32'(O_WAKE));
    step(WAKE_C - 1);
    chk("R8 last settle cycle", 32'(mode_o), 3);
    step(1);
    chk("R8 back to run", 32'(mode_o), 0);
    chk("R8 run outputs", 32'(outs()), 32'(O_RUN));
  endtask

  task automatic t_cancel();
    wr_reg(1'b0, 6'h3D);
    exti_pend = 16'h0020;
    req_sleep(1'b1);
    chk("R7 mode", 32'(mode_o), 0);
    chk("R7 outputs", 32'(outs()), 32'(O_RUN));
    exti_pend = '0;
  endtask

  // src: 0 reset pin, 1 rtc, 2 watchdog, 3 wakeup pin
  task automatic t_standby(int src);
    logic [5:0] d;
    wr_reg(1'b1, 6'h03);
    wr_reg(1'b0, 6'h3F);
    exti_pend = 16'h8001;
    if (src == 3) wkup_pin = 1'b1;
    req_sleep(1'b1);
    exti_pend = '0;
    chk("R9 mode", 32'(mode_o), 4);
    chk("R9 outputs", 32'(outs()), 32'(O_STBY));
    rd_reg(1'b1, d);
    chk("R10 flag set", 32'(d[1]), 1);
    req_sleep(1'b0);
    chk("R13 req in standby", 32'(mode_o), 4);
    if (src == 3) begin
      step(3);
      chk("R11 held pin no exit", 32'(mode_o), 4);
      wkup_pin = 1'b0;
      step(1);
      chk("R11 falling pin no exit", 32'(mode_o), 4);
      wkup_pin = 1'b1;
    end
    case (src)
      0: rst_pin_n = 1'b0;
      1: rtc_alarm = 1'b1;
      2: wdt_rst   = 1'b1;
      default: ;
    endcase
    step(1);
    rst_pin_n = 1'b1; rtc_alarm = 1'b0; wdt_rst = 1'b0; wkup_pin = 1'b0;
    chk("R11 por mode", 32'(mode_o), 5);
    chk("R11 por outputs", 32'(outs()), 32'(O_POR));
    step(POR_C - 1);
    chk("R11 last por cycle", 32'(mode_o), 5);
    step(1);
    chk("R11 run after por", 32'(mode_o), 0);
    chk("R11 run outputs", 32'(outs()), 32'(O_RUN));
    rd_reg(1'b0, d);
    chk("R11 ctrl cleared", 32'(d), 0);
    rd_reg(1'b1, d);
    chk("R10 flag kept", 32'(d[1]), 1);
    chk("R12 wake flag", 32'(d[0]), (src == 1 || src == 3) ? 1 : 0);
    wr_reg(1'b1, 6'h00);
    rd_reg(1'b1, d);
    chk("R10 R12 zero write no effect", 32'(d[1:0]), (src == 1 || src == 3) ? 3 : 2);
    wr_reg(1'b1, 6'h02);
    rd_reg(1'b1, d);
    chk("R10 clear", 32'(d[1]), 0);
    chk("R12 untouched by bit1 clear", 32'(d[0]), (src == 1 || src == 3) ? 1 : 0);
    wr_reg(1'b1, 6'h01);
    rd_reg(1'b1, d);
    chk("R12 clear", 32'(d), 0);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sleep();
    t_deep(1'b0, 2'b00, 1'b1, 1'b1);
    t_deep(1'b1, 2'b00, 1'b1, 1'b1);
    t_deep(1'b0, 2'b11, 1'b1, 1'b0);
    t_deep(1'b0, 2'b11, 1'b0, 1'b1);
    t_deep(1'b1, 2'b11, 1'b0, 1'b1);
    t_deep(1'b1, 2'b11, 1'b1, 1'b0);
    t_deep(1'b1, 2'b10, 1'b1, 1'b1);
    t_deep(1'b0, 2'b01, 1'b1, 1'b1);
    t_cancel();
    t_standby(0);
    t_standby(1);
    t_standby(2);
    t_standby(3);
    finish_up();
  end

endmodule